// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands with an iterative add-shift datapath. It consumes the multiplier operand two bits per clock. Each step looks at a three-bit window, made of two new multiplier bits and the bit just below them. It turns that window into a signed digit in the range −2..+2. It then adds the matching multiple of the multiplicand (0, ±M or ±2M) into a running partial product and shifts the whole partial-product/multiplier register right by two places with sign fill. For W-bit operands the product is ready after W/2 steps, which is half the step count of a one-bit-per-cycle shift-and-add unit.

A caller presents both operands together with a one-cycle `start` pulse while the unit is idle. The operands are captured on that edge. `busy` then stays high through the step cycles. `done` pulses for a single cycle with the registered 2W-bit product, and the product holds until the next result replaces it. The operand width `W` must be even and at least 4.

Top module: `booth_radix4_mul`

## Requirements
- R1: Before recoding, an implicit 0 sits below the multiplier's least significant bit. Step k (k = 0..W/2−1) uses the window {b(2k+1), b(2k), b(2k−1)}, so each window shares its lowest bit with the highest bit of the window before it.
- R2: A window maps to the digit −2·b(2k+1) + b(2k) + b(2k−1). Windows 000 and 111 give 0, 001 and 010 give +M, 011 gives +2M (M shifted left one place with a 0 entering at the bottom), 100 gives −2M (the two's complement of 2M), and 101 and 110 give −M.
- R3: With `done` high, `product` equals the signed product of the captured operands for every operand pair, including (−2^(W−1))·(−2^(W−1)), which is 16384 for W = 8.
- R4: When `start` is sampled high while idle, `busy` is high from the next cycle for exactly W/2 cycles. `done` rises in the cycle after the last step, and in that same cycle `busy` is low.
- R5: `done` is high for one cycle per accepted start.
- R6: A `start` sampled while `busy` is high is ignored. The running operation keeps its operands and its timing.
- R7: After synchronous reset, `busy`, `done` and `product` are 0.
- R8: `product` changes only in a cycle where `done` is high and otherwise keeps its last value.
- R9: The partial-product accumulator and its adder are W+2 bits wide so that ±2M and the running sum never overflow. After each add, the accumulator/multiplier register shifts right arithmetically by two, copying the sign bit into the two vacated top positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication; sampled only while idle |
| mcand_in | input | W | Signed multiplicand, captured on an accepted start |
| mplier_in | input | W | Signed multiplier, captured on an accepted start |
| busy | output | 1 | High while the add-shift steps run |
| done | output | 1 | One-cycle pulse marking a new product |
| product | output | 2W | Registered signed product |

## Verification
The bench builds the block with W = 8, so that operand space is small enough to sweep nearly whole. Every multiplicand value is paired with every third multiplier value from −128 to 127. Both extremes are included, and every low-bit pattern of the multiplier appears, so all eight window codes occur at every step position. All 36 pairs drawn from {−128, −127, −1, 0, 1, 127} are added to reach the overflow-prone corners, −128 × −128 among them. At W = 8 the four-step timing, the single-cycle `done`, the held product and a start that arrives mid-operation can each be timed exactly against a short fixed schedule.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  // Selection of the partial-product multiple for one radix-4 digit.
  typedef struct packed {
    logic neg;   // subtract the selected magnitude
    logic one;   // magnitude M
    logic two;   // magnitude 2M
  } booth_sel_t;

endpackage

// File: rtl/booth_digit_recoder.sv
module booth_digit_recoder
  import booth_mul_pkg::*;
(
  input  logic [2:0]  window,
  output booth_sel_t  sel
);

  // digit = -2*window[2] + window[1] + window[0]
  always_comb begin
    sel = '0;
    unique case (window)
      3'b000, 3'b111: sel = '0;
      3'b001, 3'b010: sel = '{neg: 1'b0, one: 1'b1, two: 1'b0};
      3'b011:         sel = '{neg: 1'b0, one: 1'b0, two: 1'b1};
      3'b100:         sel = '{neg: 1'b1, one: 1'b0, two: 1'b1};
      3'b101, 3'b110: sel = '{neg: 1'b1, one: 1'b1, two: 1'b0};
      default:        sel = '0;
    endcase
  end

endmodule

// File: rtl/booth_multiple_gen.sv
module booth_multiple_gen
  import booth_mul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] mcand,
  input  booth_sel_t   sel,
  output logic [W+1:0] multiple
);

  localparam int AW = W + 2;

  logic [AW-1:0] ext;
  logic [AW-1:0] mag;

  always_comb begin
    ext = {{2{mcand[W-1]}}, mcand};
    if (sel.two)      mag = {ext[AW-2:0], 1'b0};
    else if (sel.one) mag = ext;
    else              mag = '0;
    multiple = sel.neg ? (~mag + AW'(1)) : mag;
  end

endmodule

// File: rtl/booth_step_unit.sv
module booth_step_unit #(
  parameter int W = 8
) (
  input  logic [W+1:0] acc,
  input  logic [W-1:0] mq,
  input  logic [W+1:0] multiple,
  output logic [W+1:0] acc_next,
  output logic [W-1:0] mq_next,
  output logic         qx_next
);

  localparam int AW = W + 2;

  logic [AW-1:0] sum;

  always_comb begin
    sum      = acc + multiple;
    // arithmetic shift right by two across {sum, mq}
    acc_next = {sum[AW-1], sum[AW-1], sum[AW-1:2]};
    mq_next  = {sum[1:0], mq[W-1:2]};
    qx_next  = mq[1];
  end

endmodule

// File: rtl/booth_radix4_mul.sv
module booth_radix4_mul
  import booth_mul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);

  localparam int STEPS = W / 2;
  localparam int CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam int AW    = W + 2;

  logic [AW-1:0]    acc_q;
  logic [W-1:0]     mq_q;
  logic             qx_q;
  logic [W-1:0]     mcand_q;
  logic [CNT_W-1:0] step_q;

  booth_sel_t    sel;
  logic [AW-1:0] multiple;
  logic [AW-1:0] acc_d;
  logic [W-1:0]  mq_d;
  logic          qx_d;

  booth_digit_recoder u_recoder (
    .window ({mq_q[1:0], qx_q}),
    .sel    (sel)
  );

  booth_multiple_gen #(.W(W)) u_multiple (
    .mcand    (mcand_q),
    .sel      (sel),
    .multiple (multiple)
  );

  booth_step_unit #(.W(W)) u_step (
    .acc      (acc_q),
    .mq       (mq_q),
    .multiple (multiple),
    .acc_next (acc_d),
    .mq_next  (mq_d),
    .qx_next  (qx_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      product <= '0;
      acc_q   <= '0;
      mq_q    <= '0;
      qx_q    <= 1'b0;
      mcand_q <= '0;
      step_q  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          acc_q   <= '0;
          mq_q    <= mplier_in;
          qx_q    <= 1'b0;
          mcand_q <= mcand_in;
          step_q  <= '0;
        end
      end else begin
        acc_q  <= acc_d;
        mq_q   <= mq_d;
        qx_q   <= qx_d;
        step_q <= step_q + CNT_W'(1);
        if (step_q == CNT_W'(STEPS - 1)) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          product <= {acc_d[W-1:0], mq_d};
        end
      end
    end
  end

endmodule

// File: rtl/booth_mul_checker.sv
module booth_mul_checker #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [W-1:0]   mcand_in,
  input logic [W-1:0]   mplier_in,
  input logic           busy,
  input logic           done,
  input logic [2*W-1:0] product
);

  localparam int STEPS = W / 2;
  localparam int RL_W  = $clog2(STEPS + 1) + 2;

  logic [W-1:0]      ref_a;
  logic [W-1:0]      ref_b;
  logic [RL_W-1:0]   run_len;
  logic              armed;
  logic signed [2*W-1:0] ref_prod;

  always_comb begin
    ref_prod = $signed({{W{ref_a[W-1]}}, ref_a}) * $signed({{W{ref_b[W-1]}}, ref_b});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len <= '0;
      armed   <= 1'b0;
      ref_a   <= '0;
      ref_b   <= '0;
    end else begin
      armed <= 1'b1;
      if (start && !busy) begin
        ref_a   <= mcand_in;
        ref_b   <= mplier_in;
        run_len <= '0;
      end else if (busy && run_len != {RL_W{1'b1}}) begin
        run_len <= run_len + RL_W'(1);
      end
    end
  end

  // R3 (R1, R2, R9 feed into it): result matches the signed reference
  assert_product_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> product == ref_prod);

  // R4: number of busy cycles before done
  assert_step_count_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> run_len == RL_W'(STEPS));

  // R4: busy is low when the result is announced
  assert_idle_at_done_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R4: an accepted start raises busy on the next cycle
  assert_accept_R4: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R5: done is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: a start during busy does not restart the count
  assert_ignore_start_R6: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !done) |=> (busy || done));

  // R8: product holds between results
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (armed && !done) |-> $stable(product));

endmodule

bind booth_radix4_mul booth_mul_checker #(.W(W)) u_booth_mul_checker (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .mcand_in  (mcand_in),
  .mplier_in (mplier_in),
  .busy      (busy),
  .done      (done),
  .product   (product)
);

// File: tb/test_booth_radix4_mul.sv
`timescale 1ns/1ps
module test_booth_radix4_mul;

  localparam int W     = 8;
  localparam int LO    = -(1 << (W - 1));
  localparam int HI    = (1 << (W - 1)) - 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [W-1:0]   mcand_in = '0;
  logic [W-1:0]   mplier_in = '0;
  logic           busy;
  logic           done;
  logic [2*W-1:0] product;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  booth_radix4_mul #(.W(W)) i_booth_radix4_mul (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mcand_in  (mcand_in),
    .mplier_in (mplier_in),
    .busy      (busy),
    .done      (done),
    .product   (product)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int prod_val();
    return int'($signed(product));
  endfunction

  // One operation on a fixed schedule; inputs change on falling edges.
  // intr: if set, a second start with other operands is raised mid-run.
  task automatic run_op(input int a, input int b, input bit intr);
    int exp;
    exp = a * b;
    @(negedge clk);
    mcand_in  = a[W-1:0];
    mplier_in = b[W-1:0];
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R4 busy after accepted start", int'(busy), 1);
    @(negedge clk);
    if (intr) begin
      mcand_in  = (a == 0) ? 3 : -a;
      mplier_in = 5;
      start     = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b1, intr ? "R6 still running" : "R4 still running",
        int'(done), 0);
    @(negedge clk);
    // R1 R2 R3 R9: digit windows, multiples, wide adder and sign-filled shift
    chk(done == 1'b1, intr ? "R6 done timing unchanged" : "R4 done after last step",
        int'(done), 1);
    chk(busy == 1'b0, "R4 busy low at done", int'(busy), 0);
    chk(prod_val() == exp, intr ? "R6 product of original operands" : "R3 product",
        prod_val(), exp);
    @(negedge clk);
    chk(done == 1'b0, "R5 done single cycle", int'(done), 0);
    chk(prod_val() == exp, "R8 product held", prod_val(), exp);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_fails++;
    $display("FAIL R4 watchdog: actual=%0d cycles expected=completion earlier", 195000);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    int corner [6] = '{LO, LO + 1, -1, 0, 1, HI};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R7: reset state
    chk(busy == 1'b0, "R7 busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R7 done after reset", int'(done), 0);
    chk(product == '0, "R7 product after reset", prod_val(), 0);

    // R3: the most negative square, 16384 at W = 8
    run_op(LO, LO, 1'b0);

    // R6: start during busy ignored
    run_op(5, 7, 1'b1);
    run_op(-128, 127, 1'b1);
    run_op(-9, -3, 1'b1);

    // R8: nothing in between disturbs product
    repeat (5) @(negedge clk);
    chk(prod_val() == 27, "R8 product held while idle", prod_val(), 27);

    // R3 corner pairs
    foreach (corner[i]) foreach (corner[j]) run_op(corner[i], corner[j], 1'b0);

    // R1 R2 R3: all multiplicands against every third multiplier value
    for (int a = LO; a <= HI; a++) begin
      for (int b = LO; b <= HI; b += 3) begin
        run_op(a, b, 1'b0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule